// File: doc/BRIEF.md
# Per-Code Linearity Correction Stage

This stage sits directly behind an analog-to-digital converter and removes its static integral nonlinearity. Each raw converter code selects its own signed correction word from a table. The stage adds that word to the sample and passes the result downstream. No other arithmetic is involved: there is no gain term, no polynomial and no multiplier. The stage takes one sample on every clock, never stalls, and keeps its latency fixed.

A calibration host fills the table through a single-cycle write port, which has an address, a data word and an enable. The host can do this before streaming starts or while samples are flowing. After reset every correction word is zero, so the stage passes samples through unchanged until the host loads a table. The sum is clamped to the converter's code range so that an edge code never wraps around.

Top module: `inl_corrector`

## Requirements
- R1: Reset holds `outValid` at 0 and `outSample` at 0 and clears every table entry to zero, so a sample presented after reset comes out equal to its input.
- R2: A sample presented with `inValid` high comes out as the input code plus the table entry addressed by that same code.
- R3: A sum above the largest code (2^SAMPLE_W − 1, which is 1023 by default) comes out as that largest code.
- R4: A sum below zero comes out as code 0.
- R5: `outValid` equals `inValid` from two clocks earlier, so a new sample can be accepted on every clock with no stall.
- R6: A table write in cycle k is not seen by a sample presented in the same cycle k. It is seen by any sample with that code presented in cycle k+1 or later.
- R7: `outSample` keeps its last value on any cycle where `outValid` is low.
- R8: A table word is a CORR_W-bit two's complement value, so a word with its top bit set lowers the sample. For example, 6'b111011 subtracts 5.
- R9: A write changes only the entry at `wrAddr`. Samples with any other code keep their previous correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks `inSample` as a new sample this cycle |
| inSample | input | SAMPLE_W | Raw unsigned converter code |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | SAMPLE_W | Code whose correction word is written |
| wrData | input | CORR_W | Signed correction word to store |
| outValid | output | 1 | Marks `outSample` as a corrected sample |
| outSample | output | SAMPLE_W | Corrected, clamped code |

## Verification
The first input pattern runs codes through a freshly reset table. Any output that differs from its input there shows a bad reset or a bad read path. The second pattern loads a mix of positive and negative words and streams codes against them, which separates signed addition from unsigned addition and exposes any use of a wrong table index. The third pattern drives edge codes whose corrections cross either end of the range, so a clamp can be told apart from a wrap. The fourth pattern uses continuous streams, patterns with gaps, and writes that fall in the same cycle as a read, the cycle just before one, or a neighbouring address. It checks the two-cycle valid delay, the output hold, and the write-then-read ordering.

// File: rtl/inl_pkg.sv
package inl_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic tableWr;  // store wrData at wrAddr
    logic readEn;   // capture sample and its correction word
    logic sumEn;    // register the clamped sum
  } inl_ctl_t;
endpackage

// File: rtl/inl_ctrl.sv
module inl_ctrl
  import inl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  input  logic     wrEn,
  output inl_ctl_t ctl,
  output logic     outValid
);
  logic readValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      readValid <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      readValid <= inValid;
      outValid  <= readValid;
    end
  end

  always_comb begin
    ctl.tableWr = wrEn;
    ctl.readEn  = inValid;
    ctl.sumEn   = readValid;
  end
endmodule

// File: rtl/inl_datapath.sv
module inl_datapath
  import inl_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CORR_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  inl_ctl_t            ctl,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic [SAMPLE_W-1:0] wrAddr,
  input  logic [CORR_W-1:0]   wrData,
  output logic [SAMPLE_W-1:0] outSample
);
  localparam int DEPTH = 1 << SAMPLE_W;
  localparam int SUM_W = SAMPLE_W + 2;

  logic [CORR_W-1:0]   corrTable [DEPTH];
  logic [SAMPLE_W-1:0] rawQ;
  logic [CORR_W-1:0]   corrQ;
  logic [SUM_W-1:0]    sumFull;
  logic [SAMPLE_W-1:0] sumClamped;

  // One register word per code, cleared by reset
  for (genvar idx = 0; idx < DEPTH; idx++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        corrTable[idx] <= '0;
      else if (ctl.tableWr && (wrAddr == SAMPLE_W'(idx)))
        corrTable[idx] <= wrData;
    end
  end

  // Stage 1: table read indexed by the raw code
  always_ff @(posedge clk) begin
    if (rst) begin
      rawQ  <= '0;
      corrQ <= '0;
    end else if (ctl.readEn) begin
      rawQ  <= inSample;
      corrQ <= corrTable[inSample];
    end
  end

  // Signed add with clamp to [0, 2^SAMPLE_W-1]
  always_comb begin
    sumFull = {2'b00, rawQ} + {{(SUM_W-CORR_W){corrQ[CORR_W-1]}}, corrQ};
    if (sumFull[SUM_W-1])
      sumClamped = '0;
    else if (sumFull[SUM_W-2:SAMPLE_W] != '0)
      sumClamped = '1;
    else
      sumClamped = sumFull[SAMPLE_W-1:0];
  end

  // Stage 2: corrected output, held when idle
  always_ff @(posedge clk) begin
    if (rst)
      outSample <= '0;
    else if (ctl.sumEn)
      outSample <= sumClamped;
  end
endmodule

// File: rtl/inl_corrector.sv
module inl_corrector
  import inl_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CORR_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic                wrEn,
  input  logic [SAMPLE_W-1:0] wrAddr,
  input  logic [CORR_W-1:0]   wrData,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outSample
);
  inl_ctl_t ctl;

  inl_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .wrEn     (wrEn),
    .ctl      (ctl),
    .outValid (outValid)
  );

  inl_datapath #(.SAMPLE_W(SAMPLE_W), .CORR_W(CORR_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .inSample  (inSample),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .outSample (outSample)
  );
endmodule

// File: rtl/inl_corrector_chk.sv
module inl_corrector_chk #(
  parameter int SAMPLE_W = 10,
  parameter int CORR_W   = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic [SAMPLE_W-1:0] inSample,
  input logic                wrEn,
  input logic                outValid,
  input logic [SAMPLE_W-1:0] outSample
);
  localparam int HALF = 1 << (CORR_W - 1);

  logic [1:0] startCnt;
  logic       anyWrite;

  always_ff @(posedge clk) begin
    if (rst) begin
      startCnt <= 2'd0;
      anyWrite <= 1'b0;
    end else begin
      if (startCnt != 2'd2) startCnt <= startCnt + 2'd1;
      if (wrEn) anyWrite <= 1'b1;
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    (startCnt == 2'd2) |-> (outValid == $past(inValid, 2))); // R5

  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
    (startCnt == 2'd2 && !anyWrite && outValid) |-> (outSample == $past(inSample, 2))); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (startCnt == 2'd2 && !outValid) |-> $stable(outSample)); // R7

  AST_BOUNDED_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (startCnt == 2'd2 && outValid) |->
      ((int'(outSample) >= int'($past(inSample, 2)) - HALF) &&
       (int'(outSample) <= int'($past(inSample, 2)) + HALF - 1))); // R2
endmodule

bind inl_corrector inl_corrector_chk #(.SAMPLE_W(SAMPLE_W), .CORR_W(CORR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .inSample  (inSample),
  .wrEn      (wrEn),
  .outValid  (outValid),
  .outSample (outSample)
);

// File: tb/inl_corrector_tb.sv
module inl_corrector_tb_top;
  localparam int SW = 10;
  localparam int CW = 6;
  localparam int MAXC = (1 << SW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [SW-1:0] inSample = '0;
  logic          wrEn = 1'b0;
  logic [SW-1:0] wrAddr = '0;
  logic [CW-1:0] wrData = '0;
  logic          outValid;
  logic [SW-1:0] outSample;

  int checks = 0;
  int errors = 0;

  // Bench model of the table and the two-stage expectation pipe
  logic signed [CW-1:0] model [1 << SW];
  logic          expV [2];
  logic [SW-1:0] expD [2];
  string         expT [2];
  logic [SW-1:0] lastOut = '0;

  always #10 clk = ~clk;

  inl_corrector #(.SAMPLE_W(SW), .CORR_W(CW)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .outValid(outValid), .outSample(outSample)
  );

  function automatic logic [SW-1:0] expOf(input logic [SW-1:0] s);
    int sum;
    sum = int'(s) + int'(model[s]);
    if (sum < 0) return '0;
    if (sum > MAXC) return SW'(MAXC);
    return SW'(sum);
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One clock: check outputs at the falling edge, then drive the next inputs
  task automatic step(input logic r, input logic v, input logic [SW-1:0] s,
                      input logic we, input logic [SW-1:0] a, input int d,
                      input string tag);
    @(negedge clk);
    check(expT[1], int'(outValid), int'(expV[1]), "outValid");
    if (expV[1]) begin
      check(expT[1], int'(outSample), int'(expD[1]), "outSample");
      lastOut = expD[1];
    end else begin
      check(expT[1], int'(outSample), int'(lastOut), "held outSample");
    end
    expV[1] = expV[0]; expD[1] = expD[0]; expT[1] = expT[0];
    #2;
    rst = r; inValid = v; inSample = s; wrEn = we; wrAddr = a; wrData = CW'(d);
    if (r) begin
      for (int i = 0; i < (1 << SW); i++) model[i] = '0;
      expV[0] = 1'b0; expV[1] = 1'b0; expT[0] = tag; expT[1] = tag;
      lastOut = '0;
    end else begin
      expV[0] = v; expD[0] = expOf(s); expT[0] = tag;
      if (we) model[a] = CW'(d);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 1'b0, '0, 0, tag);
  endtask

  task automatic sample(input int s, input string tag);
    step(1'b0, 1'b1, SW'(s), 1'b0, '0, 0, tag);
  endtask

  task automatic load(input int a, input int d, input string tag);
    step(1'b0, 1'b0, '0, 1'b1, SW'(a), d, tag);
  endtask

  task automatic testReset();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, SW'(77), 1'b0, '0, 0, "R1_reset");
    idle(2, "R1_reset");
    sample(0, "R1"); sample(5, "R1"); sample(512, "R1"); sample(MAXC, "R1");
    idle(3, "R1");
  endtask

  task automatic testLoadStream();
    load(40, 3, "R2"); load(41, -7, "R8"); load(300, 31, "R2"); load(301, -32, "R8");
    sample(40, "R2"); sample(41, "R8"); sample(300, "R2"); sample(301, "R8");
    sample(42, "R2");
    idle(3, "R2");
  endtask

  task automatic testSaturation();
    load(MAXC - 3, 7, "R3"); load(MAXC, 1, "R3"); load(2, -5, "R4"); load(0, -1, "R4");
    sample(MAXC - 3, "R3"); sample(MAXC, "R3"); sample(2, "R4"); sample(0, "R4");
    idle(3, "R3");
  endtask

  task automatic testBackToBack();
    for (int i = 0; i < 20; i++) load(600 + i, i - 10, "R5");
    for (int i = 0; i < 20; i++) sample(600 + i, "R5");
    idle(3, "R5");
  endtask

  task automatic testWriteTiming();
    load(100, 4, "R6");
    // write and read of code 100 in the same cycle: old word applies
    step(1'b0, 1'b1, SW'(100), 1'b1, SW'(100), -9, "R6_same_cycle");
    sample(100, "R6_next_cycle");
    // write to a neighbour while streaming code 100
    step(1'b0, 1'b1, SW'(100), 1'b1, SW'(101), 12, "R9");
    sample(100, "R9"); sample(101, "R9");
    idle(3, "R6");
  endtask

  task automatic testGaps();
    load(700, 9, "R7");
    sample(700, "R7"); idle(2, "R7"); sample(10, "R7"); idle(1, "R7");
    sample(700, "R7"); idle(4, "R7");
  endtask

  initial begin
    for (int i = 0; i < (1 << SW); i++) model[i] = '0;
    expV[0] = 1'b0; expV[1] = 1'b0; expD[0] = '0; expD[1] = '0;
    expT[0] = "R1_reset"; expT[1] = "R1_reset";
    testReset();
    testLoadStream();
    testSaturation();
    testBackToBack();
    testWriteTiming();
    testGaps();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule